// File: doc/BRIEF.md
# DRAM Refresh Scheduler With Postponement

This block decides when a DDR SDRAM controller must spend a command slot on an auto-refresh, and it sequences self-refresh entry and exit. An interval timer adds one unit of refresh debt every `TICK_CYCLES` clocks. The parameter is set so that the interval stays within the 15.6 µs average refresh limit at the clock period in use. While the debt is below its cap, the refresh request is raised only when the command sequencer reports idle. When the debt reaches the cap of eight postponed refreshes, the request becomes urgent and both host-ready flags drop until the sequencer grants a refresh.

Each grant pays off one unit of debt and opens a busy window of `RFC_CYCLES` clocks. No further refresh is requested during that window. When the window closes, the request rises again if debt remains, so accumulated debt is drained as a burst of back-to-back refreshes. A self-refresh entry request drives the clock enable low and clears the debt, because the memory refreshes itself in that mode. On exit the interval timer restarts from zero. The block then holds non-read commands off for `XS_NONREAD` clocks and read commands for `XS_READ` clocks.

The state machine has four states:
- RUN: normal operation.
- REFWIN: a refresh busy window.
- SELFREF: clock enable low.
- WAKE: the self-refresh exit delay.

The state machine has five transitions:
- RUN→REFWIN on a granted request.
- RUN→SELFREF on an entry request with no grant in the same cycle.
- REFWIN→RUN when the window count reaches its last value.
- SELFREF→WAKE on an exit request.
- WAKE→RUN when the read exit delay has elapsed.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `cke`=1, `owed`=0, `ref_req`=0, `ref_urgent`=0, `ref_busy`=0, and both ready flags are 1.
- R2: Outside self-refresh, `owed` rises by one every `TICK_CYCLES` clocks. When no grant has occurred, after the k-th rising edge following reset release, `owed` equals floor(k/`TICK_CYCLES`).
- R3: In RUN with 0 < `owed` < 8, `ref_req` equals `seq_idle`.
- R4: When `owed`=8 in RUN, `ref_req`=1 and `ref_urgent`=1 regardless of `seq_idle`, and `ready_nonread`=`ready_read`=0.
- R5: `owed` never exceeds 8. A tick that arrives at 8 is dropped.
- R6: A request sampled together with `ref_grant`=1 lowers `owed` by one at that edge. `ref_busy` is then 1 for exactly `RFC_CYCLES` cycles, with `ref_req`=0 and both ready flags 0. Ticks that arrive during the window are still counted. A tick and a grant at the same edge leave `owed` unchanged.
- R7: When the busy window closes and `owed`>0 with `seq_idle`=1, `ref_req` rises in the first cycle after the window, so repeated grants drain the debt to zero.
- R8: `sr_enter`=1 in RUN, with no grant at the same edge, sets `cke`=0 and `owed`=0 at that edge. While `cke`=0, `owed` stays 0, `ref_req`=0 and both ready flags are 0.
- R9: `sr_exit`=1 in self-refresh raises `cke` at that edge (the exit edge). `ready_nonread` becomes 1 at the `XS_NONREAD`-th edge after the exit edge, and `ready_read` becomes 1 at the `XS_READ`-th edge.
- R10: The debt is 0 at the exit edge and the interval restarts there, so `owed` becomes 1 at the `TICK_CYCLES`-th edge after the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_idle | input | 1 | Command sequencer has no host work pending |
| ref_grant | input | 1 | Sequencer issues the requested refresh this edge |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh wanted |
| ref_urgent | output | 1 | Debt at cap; refresh must go first |
| ref_busy | output | 1 | Refresh busy window open |
| cke | output | 1 | Clock enable to the memory |
| ready_nonread | output | 1 | Non-read commands may be issued |
| ready_read | output | 1 | Read commands may be issued |
| owed | output | $clog2(MAX_DEBT+1) | Postponed refresh count |

## Verification
A timer tick and a refresh grant can land on the same clock edge. The first would raise the debt and the second would lower it. The bench provokes this by holding the grant high in the cycle just before the edge at which the interval timer expires. It judges the result by reading `owed` after that edge, which must equal its value before the grant, with `ref_busy` raised. A second overlap places a tick inside an open busy window, and the debt must still rise there while the request stays low.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_REFWIN  = 2'd1,
        ST_SELFREF = 2'd2,
        ST_WAKE    = 2'd3
    } rs_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer #(
    parameter int TICK_CYCLES = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R2: ticks are separated by the interval, never back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic [$clog2(MAX_DEBT+1)-1:0] level,
    output logic full
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (q != CAP) q <= q + DW'(1);
                2'b01:   if (q != '0)  q <= q - DW'(1);
                default: q <= q;
            endcase
        end
    end

    assign level = q;
    assign full  = (q == CAP);

    // R5: debt is capped
    a_r5_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q <= CAP);
    // R6: a lone payment lowers the debt by one
    a_r6_pay_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr && q != '0) |=> (q == $past(q) - DW'(1)));
    // R6: tick and payment together cancel
    a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && inc && !clr) |=> $stable(q));
endmodule

// File: rtl/refsched_window.sv
module refsched_window #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + WIDTH'(1);
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsched_pkg::*;
#(
    parameter int TICK_CYCLES = 2080,
    parameter int MAX_DEBT    = 8,
    parameter int RFC_CYCLES  = 10,
    parameter int XS_NONREAD  = 10,
    parameter int XS_READ     = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_idle,
    input  logic ref_grant,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic cke,
    output logic ready_nonread,
    output logic ready_read,
    output logic [$clog2(MAX_DEBT+1)-1:0] owed
);
    localparam int WW = $clog2(max2(RFC_CYCLES, XS_READ) + 1);
    localparam logic [WW-1:0] RFC_LAST  = WW'(RFC_CYCLES - 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(XS_READ - 1);
    localparam logic [WW-1:0] NR_OK     = WW'(XS_NONREAD);

    rs_state_t state_q, state_d;
    logic          tick, full, take_ref, take_enter, win_clr, win_en;
    logic [WW-1:0] win_cnt;

    refsched_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_SELFREF),
        .tick  (tick)
    );

    refsched_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (take_ref),
        .clr   ((state_q == ST_SELFREF) || take_enter),
        .level (owed),
        .full  (full)
    );

    refsched_window #(.WIDTH(WW)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .en    (win_en),
        .count (win_cnt)
    );

    assign take_ref   = (state_q == ST_RUN) && ref_req && ref_grant;
    assign take_enter = (state_q == ST_RUN) && !take_ref && sr_enter;
    assign win_clr    = (state_d != state_q);
    assign win_en     = (state_q == ST_REFWIN) || (state_q == ST_WAKE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_ref)        state_d = ST_REFWIN;
                else if (take_enter) state_d = ST_SELFREF;
            end
            ST_REFWIN:  if (win_cnt == RFC_LAST)  state_d = ST_RUN;
            ST_SELFREF: if (sr_exit)              state_d = ST_WAKE;
            ST_WAKE:    if (win_cnt == WAKE_LAST) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        ref_req       = 1'b0;
        ref_urgent    = 1'b0;
        ref_busy      = 1'b0;
        cke           = 1'b1;
        ready_nonread = 1'b0;
        ready_read    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                ref_req       = (owed != '0) && (seq_idle || full);
                ref_urgent    = full;
                ready_nonread = !full;
                ready_read    = !full;
            end
            ST_REFWIN: begin
                ref_busy   = 1'b1;
                ref_urgent = full;
            end
            ST_SELFREF: cke = 1'b0;
            ST_WAKE:    ready_nonread = (win_cnt >= NR_OK);
            default: ;
        endcase
    end

    // R4: urgency holds host traffic off
    a_r4_urgent_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (!ready_nonread && !ready_read));
    // R6: a granted request opens the busy window
    a_r6_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant) |=> ref_busy);
    // R6: no request while the window is open
    a_r6_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> !ref_req);
    // R7: leftover debt is requested as soon as the window closes
    a_r7_burst_drain: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_busy) && owed != '0 && seq_idle) |-> ref_req);
    // R8: nothing is requested or admitted while the clock is gated
    a_r8_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!ref_req && !ready_nonread && !ready_read && owed == '0));
    // R9: read readiness never precedes non-read readiness
    a_r9_read_after_nonread: assert property (@(posedge clk) disable iff (!rst_n)
        ready_read |-> ready_nonread);
    // R10: debt is clear at the exit edge
    a_r10_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (owed == '0));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int T   = 32;
    localparam int RFC = 10;
    localparam int XNR = 10;
    localparam int XRD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_idle = 1'b0, ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_urgent, ref_busy, cke, ready_nonread, ready_read;
    logic [3:0] owed;
    int edges = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    dram_refresh_sched #(
        .TICK_CYCLES(T), .MAX_DEBT(8), .RFC_CYCLES(RFC),
        .XS_NONREAD(XNR), .XS_READ(XRD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .ref_grant(ref_grant),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_busy(ref_busy), .cke(cke),
        .ready_nonread(ready_nonread), .ready_read(ready_read), .owed(owed)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, edges, act, exp);
        end
    endtask

    task automatic upto(input int n);
        while (edges < n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 cke", cke, 1);
        check("R1 owed", owed, 0);
        check("R1 req", ref_req, 0);
        check("R1 urgent", ref_urgent, 0);
        check("R1 busy", ref_busy, 0);
        check("R1 ready_nonread", ready_nonread, 1);
        check("R1 ready_read", ready_read, 1);
    endtask

    task automatic t_ticks;
        upto(T - 1);
        check("R2 owed before first tick", owed, 0);
        upto(T);
        check("R2 owed first tick", owed, 1);
        upto(2 * T);
        check("R2 owed second tick", owed, 2);
        check("R3 no req while sequencer busy", ref_req, 0);
        seq_idle = 1'b1;
        #1;
        check("R3 req when idle", ref_req, 1);
    endtask

    task automatic t_grant_window;
        ref_grant = 1'b1;
        upto(2 * T + 1);
        ref_grant = 1'b0;
        check("R6 owed after grant", owed, 1);
        check("R6 busy", ref_busy, 1);
        check("R6 req in window", ref_req, 0);
        check("R6 ready_nonread in window", ready_nonread, 0);
        upto(2 * T + RFC);
        check("R6 busy last window cycle", ref_busy, 1);
        upto(2 * T + RFC + 1);
        check("R6 window closed", ref_busy, 0);
        check("R7 req after window", ref_req, 1);
    endtask

    task automatic t_tick_in_window;
        upto(3 * T - 3);
        ref_grant = 1'b1;
        upto(3 * T - 2);
        ref_grant = 1'b0;
        check("R6 owed paid", owed, 0);
        upto(3 * T + 2);
        check("R6 tick counted in window", owed, 1);
        check("R6 req quiet in window", ref_req, 0);
        upto(3 * T - 2 + RFC);
        check("R7 req rises after window", ref_req, 1);
    endtask

    task automatic t_coincide;
        upto(4 * T - 1);
        ref_grant = 1'b1;
        upto(4 * T);
        ref_grant = 1'b0;
        seq_idle = 1'b0;
        check("R6 tick and grant cancel", owed, 1);
        check("R6 busy on coincident grant", ref_busy, 1);
    endtask

    task automatic t_urgent;
        upto(11 * T - 1);
        check("R3 owed before cap", owed, 7);
        check("R3 no req at 7 when busy", ref_req, 0);
        check("R4 ready before cap", ready_nonread, 1);
        upto(11 * T);
        check("R4 owed at cap", owed, 8);
        check("R4 req forced", ref_req, 1);
        check("R4 urgent", ref_urgent, 1);
        check("R4 ready_nonread blocked", ready_nonread, 0);
        check("R4 ready_read blocked", ready_read, 0);
        upto(12 * T);
        check("R5 owed saturates", owed, 8);
    endtask

    task automatic t_drain;
        int grants = 0;
        seq_idle = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            #1;
            if (owed == 0 && !ref_busy) break;
            if (ref_req) begin
                ref_grant = 1'b1;
                @(negedge clk);
                ref_grant = 1'b0;
                #1;
                grants++;
                if (grants == 1) begin
                    check("R6 first drain pays one", owed, 7);
                    check("R4 urgency drops", ref_urgent, 0);
                end
            end
        end
        check("R7 debt drained", owed, 0);
        check("R7 window closed after drain", ref_busy, 0);
    endtask

    task automatic t_selfref;
        int e;
        seq_idle = 1'b0;
        @(negedge clk);
        #1;
        sr_enter = 1'b1;
        e = edges;
        upto(e + 1);
        sr_enter = 1'b0;
        check("R8 cke low", cke, 0);
        check("R8 owed cleared", owed, 0);
        check("R8 ready_read low", ready_read, 0);
        upto(e + 1 + 2 * T);
        check("R8 no ticks owed", owed, 0);
        check("R8 no req", ref_req, 0);
        sr_exit = 1'b1;
        e = edges + 1;
        upto(e);
        sr_exit = 1'b0;
        check("R9 cke high at exit", cke, 1);
        check("R10 owed zero at exit", owed, 0);
        upto(e + XNR - 1);
        check("R9 nonread still held", ready_nonread, 0);
        upto(e + XNR);
        check("R9 nonread ready", ready_nonread, 1);
        check("R9 read still held", ready_read, 0);
        upto(e + T - 1);
        check("R10 interval restarted", owed, 0);
        upto(e + T);
        check("R10 first tick after exit", owed, 1);
        upto(e + XRD - 1);
        check("R9 read held last cycle", ready_read, 0);
        upto(e + XRD);
        check("R9 read ready", ready_read, 1);
        check("R9 nonread still ready", ready_nonread, 1);
    endtask

    initial begin
        t_reset();
        t_ticks();
        t_grant_window();
        t_tick_in_window();
        t_coincide();
        t_urgent();
        t_drain();
        t_selfref();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired at edge %0d: actual=hung expected=done", edges);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule